// File: doc/BRIEF.md
# Aging Counter Replacement Unit

This block tracks how recently each of a fixed set of memory frames has been used, so that a replacement policy can pick a frame to evict. Every frame owns a small usage counter and a single "used since the last tick" flag. A use of a frame raises that frame's flag. A periodic tick moves every counter one place toward its low end. On the same tick, each frame's flag drops into the counter's top bit, and the flag is then cleared. Recent use therefore weighs more than old use, and usage that is never repeated fades away after as many ticks as the counter has bits.

The unit always presents the index of the frame whose counter holds the smallest value, together with that value. This frame is the one least recently used. The search runs combinationally over all counters. When counters are equal, the lowest frame index wins. The tick source and the eviction itself belong to the surrounding logic.

Top module: `aging_repl_unit`

## Requirements
- R1: After reset every counter and every use flag is zero, so the outputs read victim index 0 with value 0.
- R2: A reference (ref_valid high with frame number ref_frame) raises only that frame's use flag. Without a tick it leaves every counter unchanged.
- R3: On a tick each counter shifts right by one bit, halving its value.
- R4: On a tick the frame's use flag enters the counter's most significant bit, so a frame referenced since the previous tick gains 2^(AGE_W-1), which is 32 for 6-bit counters.
- R5: A tick clears every use flag that it sampled. A later tick with no reference in between inserts 0.
- R6: A reference in the same cycle as a tick is not lost. It sets the flag that the following tick samples.
- R7: victim_age equals the smallest counter value, and victim_idx names a frame that holds it.
- R8: When several frames share the smallest value, victim_idx is the lowest such index.
- R9: Counters change only on a tick.
- R10: With 6-bit counters, a frame referenced only in the latest tick reads 32, while frames referenced in each of the last six ticks read 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Aging strobe, one cycle per aging period |
| ref_valid | input | 1 | A frame was used this cycle |
| ref_frame | input | IDX_W | Index of the used frame |
| victim_idx | output | IDX_W | Frame with the smallest counter, lowest index on ties |
| victim_age | output | AGE_W | Counter value of that frame |

## Verification
The bench builds the unit with its defaults: 8 frames and 6-bit counters. With these values a counter saturates or drains within six ticks, so a few thousand cycles of mixed references and ticks visit full, empty and partly aged counters many times over. Eight frames also make ties among equal values common, which exercises the lowest-index rule. Directed sequences force a single frame's counter to be the unique minimum, so that the exact shift, flag insertion and tick/reference collision results become visible at the outputs.

// File: rtl/aging_pkg.sv
package aging_pkg;

  // One aging step: shift right by one, insert the use flag at bit w-1.
  function automatic logic [31:0] age_step(input logic [31:0] cur,
                                           input logic       used,
                                           input int         w);
    logic [31:0] nxt;
    nxt = cur >> 1;
    if (used) nxt = nxt | (32'd1 << (w - 1));
    return nxt;
  endfunction

  // True when candidate must replace the running best (strictly smaller).
  function automatic logic age_beats(input logic [31:0] cand,
                                     input logic [31:0] best);
    return cand < best;
  endfunction

endpackage

// File: rtl/aging_frame.sv
module aging_frame #(
  parameter int AGE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             tick,
  output logic [AGE_W-1:0] age_o,
  output logic             used_o
);
  import aging_pkg::*;

  logic [AGE_W-1:0] age_q;
  logic             used_q;
  logic [AGE_W-1:0] age_next;

  assign age_next = AGE_W'(age_step(32'(age_q), used_q, AGE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      used_q <= 1'b0;
    end else if (tick) begin
      age_q  <= age_next;
      used_q <= hit;           // collision: keep it for the next tick
    end else if (hit) begin
      used_q <= 1'b1;
    end
  end

  assign age_o  = age_q;
  assign used_o = used_q;
endmodule

// File: rtl/aging_min_pick.sv
module aging_min_pick #(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 6,
  parameter int IDX_W      = 3
) (
  input  logic [NUM_FRAMES*AGE_W-1:0] ages,
  output logic [IDX_W-1:0]            min_idx,
  output logic [AGE_W-1:0]            min_age
);
  import aging_pkg::*;

  always_comb begin
    min_idx = '0;
    min_age = ages[AGE_W-1:0];
    for (int i = 1; i < NUM_FRAMES; i++) begin
      if (age_beats(32'(ages[i*AGE_W +: AGE_W]), 32'(min_age))) begin
        min_idx = IDX_W'(i);
        min_age = ages[i*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/aging_repl_unit.sv
module aging_repl_unit #(
  parameter  int NUM_FRAMES = 8,
  parameter  int AGE_W      = 6,
  localparam int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  output logic [IDX_W-1:0] victim_idx,
  output logic [AGE_W-1:0] victim_age
);

  logic [NUM_FRAMES-1:0]       ref_hit;
  logic [NUM_FRAMES-1:0]       used_bits;
  logic [NUM_FRAMES*AGE_W-1:0] age_flat;

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    assign ref_hit[f] = ref_valid && (ref_frame == IDX_W'(f));

    aging_frame #(.AGE_W(AGE_W)) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (ref_hit[f]),
      .tick   (tick),
      .age_o  (age_flat[f*AGE_W +: AGE_W]),
      .used_o (used_bits[f])
    );
  end

  aging_min_pick #(
    .NUM_FRAMES (NUM_FRAMES),
    .AGE_W      (AGE_W),
    .IDX_W      (IDX_W)
  ) u_pick (
    .ages    (age_flat),
    .min_idx (victim_idx),
    .min_age (victim_age)
  );

endmodule

// File: rtl/aging_repl_chk.sv
module aging_repl_chk #(
  parameter int NF = 8,
  parameter int AW = 6,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ref_valid,
  input logic [IW-1:0] ref_frame,
  input logic [IW-1:0] victim_idx,
  input logic [AW-1:0] victim_age,
  input logic [NF*AW-1:0] age_flat,
  input logic [NF-1:0] used_bits
);

  // R9
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(age_flat));

  // R7
  victim_value_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    age_flat[victim_idx*AW +: AW] == victim_age);

  for (genvar f = 0; f < NF; f++) begin : g_chk
    // R3
    shift_low_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> age_flat[f*AW +: AW-1] == $past(age_flat[f*AW+1 +: AW-1]));

    // R4
    flag_to_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> age_flat[f*AW+AW-1] == $past(used_bits[f]));

    // R5
    flag_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(ref_valid && ref_frame == IW'(f))) |=> !used_bits[f]);

    // R6
    collision_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ref_valid && ref_frame == IW'(f)) |=> used_bits[f]);

    // R2
    ref_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_valid && ref_frame == IW'(f)) |=> used_bits[f]);

    // R7
    victim_is_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      victim_age <= age_flat[f*AW +: AW]);

    // R8
    lowest_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (IW'(f) < victim_idx) |-> age_flat[f*AW +: AW] != victim_age);
  end

endmodule

bind aging_repl_unit aging_repl_chk #(
  .NF (NUM_FRAMES),
  .AW (AGE_W),
  .IW (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .ref_valid  (ref_valid),
  .ref_frame  (ref_frame),
  .victim_idx (victim_idx),
  .victim_age (victim_age),
  .age_flat   (age_flat),
  .used_bits  (used_bits)
);

// File: tb/aging_repl_unit_tb.sv
`timescale 1ns/1ps
module aging_repl_unit_tb;
  localparam int NF = 8;
  localparam int AW = 6;
  localparam int TOP = 1 << (AW - 1);
  localparam int MASK = (1 << AW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ref_valid = 1'b0;
  logic [2:0] ref_frame = '0;
  logic [2:0] victim_idx;
  logic [5:0] victim_age;

  int n_chk = 0;
  int n_err = 0;
  int m_age[NF];
  int m_used[NF];

  always #10 clk = ~clk;

  aging_repl_unit #(.NUM_FRAMES(NF), .AGE_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ref_valid(ref_valid),
    .ref_frame(ref_frame), .victim_idx(victim_idx), .victim_age(victim_age)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_idx();
    int best = NF - 1;
    for (int i = NF - 1; i >= 0; i--)
      if (m_age[i] <= m_age[best]) best = i;
    return best;
  endfunction

  task automatic check_model(input string tag);
    int e = exp_idx();
    chk({tag, " idx"}, int'(victim_idx), e);
    chk({tag, " age"}, int'(victim_age), m_age[e]);
  endtask

  // One clock: drive at the falling edge, update the model at the rising
  // edge, compare at the next falling edge.
  task automatic cyc(input bit rv, input int rf, input bit tk);
    ref_valid = rv;
    ref_frame = 3'(rf);
    tick      = tk;
    @(posedge clk);
    for (int f = 0; f < NF; f++) begin
      bit h = rv && (rf == f);
      if (tk) begin
        m_age[f]  = ((m_age[f] / 2) + (m_used[f] != 0 ? TOP : 0)) & MASK;
        m_used[f] = h ? 1 : 0;
      end else if (h) begin
        m_used[f] = 1;
      end
    end
    @(negedge clk);
    ref_valid = 1'b0;
    tick      = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int f = 0; f < NF; f++) begin
      m_age[f] = 0;
      m_used[f] = 0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 reset idx", int'(victim_idx), 0);
    chk("R1 reset age", int'(victim_age), 0);

    // R2 and R9: references alone leave all counters at zero
    cyc(1, 0, 0);
    cyc(1, 3, 0);
    chk("R2 no tick idx", int'(victim_idx), 0);
    chk("R9 no tick age", int'(victim_age), 0);
    // R8: frames 0 and 3 now hold 32, lowest zero frame is 1
    cyc(0, 0, 1);
    chk("R8 tie lowest idx", int'(victim_idx), 1);
    chk("R4 others zero", int'(victim_age), 0);
    check_model("R8 model");

    // R6 and R5: collision kept, then cleared
    do_reset();
    for (int f = 1; f < NF; f++) cyc(1, f, 0);
    cyc(1, 0, 1);              // frames 1..7 -> 32, frame 0 -> 0
    chk("R6 collision pre idx", int'(victim_idx), 0);
    chk("R6 collision pre age", int'(victim_age), 0);
    cyc(0, 0, 1);              // frame 0 -> 32, others -> 16
    chk("R6 kept flag idx", int'(victim_idx), 1);
    chk("R6 kept flag age", int'(victim_age), 16);
    cyc(0, 0, 1);              // frame 0 -> 16, others -> 8
    chk("R5 cleared idx", int'(victim_idx), 1);
    chk("R3 halved age", int'(victim_age), 8);
    check_model("R3 model");

    // R10: frame 5 referenced only in the latest tick -> 32, others 63
    do_reset();
    for (int t = 0; t < AW; t++) begin
      for (int f = 0; f < NF; f++)
        if (f != 5 || t == AW - 1) cyc(1, f, 0);
      cyc(0, 0, 1);
    end
    chk("R10 latest only idx", int'(victim_idx), 5);
    chk("R10 latest only age", int'(victim_age), TOP);
    cyc(0, 0, 1);              // R3: 32 -> 16 while 63 -> 31
    chk("R3 one more tick", int'(victim_age), TOP / 2);

    // R7: long mixed sweep against the arithmetic model
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 15));
      cyc(r[0], int'($urandom_range(0, NF - 1)), (r[3:2] == 2'b00));
      check_model("R7 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule